// File: doc/BRIEF.md
# Real-Time Match Counter

This block is a free-running 32-bit up-counter for wall-clock timekeeping. It is paced by a slow pin, nominally 32.768 kHz, that is asynchronous to the system clock. The pin is synchronized inside the block. Each rising edge of the pin advances the count by one while the timer is enabled and in real-time mode.

A programmable compare value sets a sticky raw status flag on the clock edge at which the count takes that value. Counting then carries on without a stop or a reload. Software clears the flag with a write-one clear pulse. A mask bit gates the flag onto the interrupt pin.

The mode, stall, start-value and compare settings can be changed only while the timer is stopped. The run bit itself can be written at any time. Software stops the timer, programs a start value and a compare value, and then starts it again. An optional stall input freezes the count, for example while a processor is halted in debug.

Top module: `rtc_match_timer`

## Requirements
- R1: After reset the count is 0, the raw status, interrupt, mask, run, mode and stall-enable bits are 0, and the compare value is 0.
- R2: With run and mode bits set, each rising edge of `tick_in` advances `count_o` by exactly one. The new value appears after the third rising clock edge counted from the first edge that samples `tick_in` high. It has not appeared after the second.
- R3: A high level on `tick_in` lasting many clock cycles advances the count once, not once per cycle.
- R4: When either the run bit or the mode bit is clear, ticks leave the count unchanged.
- R5: While `stall_in` is high and the stall-enable bit is set, ticks are ignored. `stall_in` has no effect while stall-enable is clear.
- R6: The raw status rises on the clock edge at which the count takes the compare value, and the count keeps advancing on later ticks.
- R7: Raw status stays set until a cycle with `int_clr` high. It then reads 0 on the next cycle.
- R8: If the set event and `int_clr` fall in the same cycle, the status is left set.
- R9: The count wraps from 0xFFFFFFFF to 0, and a compare value of 0 is matched at that wrap.
- R10: A write of `load_d` while the run bit is clear sets the count to that value. While the run bit is set, the write is ignored.
- R11: While the run bit is set, writes of the compare value and of the mode and stall-enable bits are ignored. The run bit itself is always written by `ctl_we`.
- R12: `irq_o` is high exactly when raw status and the mask bit are both 1. The mask is writable at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_in | input | 1 | Slow timekeeping pin, asynchronous |
| stall_in | input | 1 | Freeze request, honoured when stall-enable is set |
| ctl_we | input | 1 | Control write strobe |
| ctl_en_d | input | 1 | Run bit write data |
| ctl_rtc_en_d | input | 1 | Real-time mode bit write data |
| ctl_stall_en_d | input | 1 | Stall-enable bit write data |
| load_we | input | 1 | Start-value write strobe |
| load_d | input | 32 | Start value |
| match_we | input | 1 | Compare write strobe |
| match_d | input | 32 | Compare value |
| mask_we | input | 1 | Mask write strobe |
| mask_d | input | 1 | Mask write data |
| int_clr | input | 1 | Write-one clear of raw status |
| ctl_en_o | output | 1 | Run bit readback |
| ctl_rtc_en_o | output | 1 | Mode bit readback |
| ctl_stall_en_o | output | 1 | Stall-enable readback |
| match_o | output | 32 | Compare value readback |
| mask_o | output | 1 | Mask readback |
| count_o | output | 32 | Current count |
| raw_status_o | output | 1 | Sticky match flag |
| irq_o | output | 1 | Masked interrupt |

## Verification
The counting path is driven with isolated pulses, long high levels and pulses held during a stall request. These show whether the edge detector counts once per edge and whether stall honours its enable bit. Compare values just ahead of the count, behind it and at zero after a forced wrap show whether the flag fires on equality alone and whether the wrap reaches zero. Writes issued while running, and a clear timed into the very cycle of a match, show whether the run-time write lockout holds and whether set beats clear.

// File: rtl/rtc_match_pkg.sv
package rtc_match_pkg;
  localparam int unsigned CNT_W = 32;

  typedef struct packed {
    logic run;
    logic rtc_mode;
    logic stall_en;
  } rtc_ctl_t;
endpackage

// File: rtl/rtc_tick_sync.sv
module rtc_tick_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  output logic tick_pulse
);
  // Synchronizer stages followed by one history flop for edge detection.
  localparam int unsigned LAST = STAGES;

  logic [LAST:0] sr_q;

  generate
    if (STAGES < 2) begin : g_bad
      initial $error("rtc_tick_sync: STAGES must be at least 2");
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[LAST-1:0], tick_in};
  end

  assign tick_pulse = sr_q[LAST-1] & ~sr_q[LAST];
endmodule

// File: rtl/rtc_cfg_regs.sv
module rtc_cfg_regs
  import rtc_match_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctl_we,
  input  rtc_ctl_t     ctl_d,
  input  logic         match_we,
  input  logic [W-1:0] match_d,
  input  logic         mask_we,
  input  logic         mask_d,
  output rtc_ctl_t     ctl_q,
  output logic [W-1:0] match_q,
  output logic         mask_q
);
  // Everything except the run bit and the mask is locked while running.
  logic unlocked;
  assign unlocked = ~ctl_q.run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      match_q <= '0;
      mask_q  <= 1'b0;
    end else begin
      if (ctl_we) begin
        ctl_q.run <= ctl_d.run;
        if (unlocked) begin
          ctl_q.rtc_mode <= ctl_d.rtc_mode;
          ctl_q.stall_en <= ctl_d.stall_en;
        end
      end
      if (match_we && unlocked) match_q <= match_d;
      if (mask_we)              mask_q  <= mask_d;
    end
  end
endmodule

// File: rtl/rtc_count_core.sv
module rtc_count_core
  import rtc_match_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  rtc_ctl_t     ctl,
  input  logic         tick_pulse,
  input  logic         stall_in,
  input  logic         load_we,
  input  logic [W-1:0] load_d,
  input  logic [W-1:0] match_val,
  output logic [W-1:0] count_q,
  output logic         hit
);
  logic         frozen;
  logic         advance;
  logic [W-1:0] count_inc;

  assign frozen    = ctl.stall_en & stall_in;
  assign advance   = ctl.run & ctl.rtc_mode & tick_pulse & ~frozen;
  assign count_inc = count_q + W'(1);   // natural wrap at all-ones
  assign hit       = advance && (count_inc == match_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   count_q <= '0;
    else if (load_we && !ctl.run) count_q <= load_d;
    else if (advance)             count_q <= count_inc;
  end
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic clr,
  input  logic mask,
  output logic status_q,
  output logic irq
);
  // A new match wins over a simultaneous clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   status_q <= 1'b0;
    else if (hit) status_q <= 1'b1;
    else if (clr) status_q <= 1'b0;
  end

  assign irq = status_q & mask;
endmodule

// File: rtl/rtc_match_timer.sv
module rtc_match_timer
  import rtc_match_pkg::*;
#(
  parameter int unsigned W           = CNT_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_in,
  input  logic         stall_in,
  input  logic         ctl_we,
  input  logic         ctl_en_d,
  input  logic         ctl_rtc_en_d,
  input  logic         ctl_stall_en_d,
  input  logic         load_we,
  input  logic [W-1:0] load_d,
  input  logic         match_we,
  input  logic [W-1:0] match_d,
  input  logic         mask_we,
  input  logic         mask_d,
  input  logic         int_clr,
  output logic         ctl_en_o,
  output logic         ctl_rtc_en_o,
  output logic         ctl_stall_en_o,
  output logic [W-1:0] match_o,
  output logic         mask_o,
  output logic [W-1:0] count_o,
  output logic         raw_status_o,
  output logic         irq_o
);
  rtc_ctl_t     ctl_wr;
  rtc_ctl_t     ctl_q;
  logic [W-1:0] match_q;
  logic         mask_q;
  logic         tick_pulse;
  logic         hit;

  assign ctl_wr = '{run: ctl_en_d, rtc_mode: ctl_rtc_en_d, stall_en: ctl_stall_en_d};

  rtc_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_in    (tick_in),
    .tick_pulse (tick_pulse)
  );

  rtc_cfg_regs #(.W(W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_we   (ctl_we),
    .ctl_d    (ctl_wr),
    .match_we (match_we),
    .match_d  (match_d),
    .mask_we  (mask_we),
    .mask_d   (mask_d),
    .ctl_q    (ctl_q),
    .match_q  (match_q),
    .mask_q   (mask_q)
  );

  rtc_count_core #(.W(W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl        (ctl_q),
    .tick_pulse (tick_pulse),
    .stall_in   (stall_in),
    .load_we    (load_we),
    .load_d     (load_d),
    .match_val  (match_q),
    .count_q    (count_o),
    .hit        (hit)
  );

  rtc_irq_ctrl u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit      (hit),
    .clr      (int_clr),
    .mask     (mask_q),
    .status_q (raw_status_o),
    .irq      (irq_o)
  );

  assign ctl_en_o       = ctl_q.run;
  assign ctl_rtc_en_o   = ctl_q.rtc_mode;
  assign ctl_stall_en_o = ctl_q.stall_en;
  assign match_o        = match_q;
  assign mask_o         = mask_q;
endmodule

// File: rtl/rtc_match_timer_chk.sv
module rtc_match_timer_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         load_we,
  input logic         int_clr,
  input logic         ctl_en_o,
  input logic         ctl_rtc_en_o,
  input logic         ctl_stall_en_o,
  input logic [W-1:0] match_o,
  input logic         mask_o,
  input logic [W-1:0] count_o,
  input logic         raw_status_o,
  input logic         irq_o
);
  // R2: outside a load, the count only ever moves forward by one
  a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(count_o) && !$past(load_we)) |-> (count_o == $past(count_o) + W'(1)));

  // R4: a stopped timer keeps its count unless loaded
  a_r4_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ctl_en_o) && !$past(load_we)) |-> $stable(count_o));

  // R6: the flag rises only when the count equals the compare value
  a_r6_rise_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_status_o) |-> (count_o == match_o));

  // R7: flag is sticky without a clear
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(raw_status_o) && !$past(int_clr)) |-> raw_status_o);

  // R11: compare and mode settings are frozen while running
  a_r11_locked: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctl_en_o) |-> ($stable(match_o) && $stable(ctl_rtc_en_o) && $stable(ctl_stall_en_o)));

  // R12: the interrupt needs both the mask and the flag
  a_r12_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (mask_o && raw_status_o));
endmodule

bind rtc_match_timer rtc_match_timer_chk #(.W(W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .load_we        (load_we),
  .int_clr        (int_clr),
  .ctl_en_o       (ctl_en_o),
  .ctl_rtc_en_o   (ctl_rtc_en_o),
  .ctl_stall_en_o (ctl_stall_en_o),
  .match_o        (match_o),
  .mask_o         (mask_o),
  .count_o        (count_o),
  .raw_status_o   (raw_status_o),
  .irq_o          (irq_o)
);

// File: tb/rtc_match_timer_tb.sv
`timescale 1ns/1ps
module rtc_match_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_in = 1'b0, stall_in = 1'b0;
  logic        ctl_we = 1'b0, ctl_en_d = 1'b0, ctl_rtc_en_d = 1'b0, ctl_stall_en_d = 1'b0;
  logic        load_we = 1'b0, match_we = 1'b0, mask_we = 1'b0, mask_d = 1'b0, int_clr = 1'b0;
  logic [31:0] load_d = '0, match_d = '0;
  logic        ctl_en_o, ctl_rtc_en_o, ctl_stall_en_o, mask_o, raw_status_o, irq_o;
  logic [31:0] match_o, count_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // expected state
  logic [31:0] m_cnt = '0, m_match = '0;
  logic        m_run = 0, m_rtc = 0, m_stall = 0, m_mask = 0, m_stat = 0;

  always #10 clk = ~clk;   // 50 MHz

  rtc_match_timer u_dut (.*);

  function automatic logic exp_irq();
    return m_stat & m_mask;
  endfunction

  function automatic logic tick_counts(input logic stl);
    return m_run & m_rtc & ~(m_stall & stl);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(count_o == m_cnt, req, count_o, m_cnt);
    chk(raw_status_o == m_stat, req, 32'(raw_status_o), 32'(m_stat));
    chk(irq_o == exp_irq(), {req, "/R12"}, 32'(irq_o), 32'(exp_irq()));
    chk(match_o == m_match, {req, "/R11"}, match_o, m_match);
    chk({ctl_en_o, ctl_rtc_en_o, ctl_stall_en_o} == {m_run, m_rtc, m_stall},
        {req, "/R11"}, 32'({ctl_en_o, ctl_rtc_en_o, ctl_stall_en_o}), 32'({m_run, m_rtc, m_stall}));
  endtask

  task automatic wr_ctl(input logic r, input logic m, input logic s);
    @(negedge clk);
    ctl_we = 1; ctl_en_d = r; ctl_rtc_en_d = m; ctl_stall_en_d = s;
    @(negedge clk); ctl_we = 0;
    if (!m_run) begin m_rtc = m; m_stall = s; end
    m_run = r;
  endtask

  task automatic wr_load(input logic [31:0] v);
    @(negedge clk); load_we = 1; load_d = v;
    @(negedge clk); load_we = 0;
    if (!m_run) m_cnt = v;
  endtask

  task automatic wr_match(input logic [31:0] v);
    @(negedge clk); match_we = 1; match_d = v;
    @(negedge clk); match_we = 0;
    if (!m_run) m_match = v;
  endtask

  task automatic wr_mask(input logic v);
    @(negedge clk); mask_we = 1; mask_d = v;
    @(negedge clk); mask_we = 0;
    m_mask = v;
  endtask

  task automatic do_clear();
    @(negedge clk); int_clr = 1;
    @(negedge clk); int_clr = 0;
    m_stat = 0;
  endtask

  task automatic do_tick(input logic stl, input int hold);
    @(negedge clk); stall_in = stl; tick_in = 1;
    repeat (hold) @(negedge clk);
    tick_in = 0;
    repeat (5) @(negedge clk);
    stall_in = 0;
    if (tick_counts(stl)) begin
      m_cnt = m_cnt + 1;
      if (m_cnt == m_match) m_stat = 1;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h1c0ffee5));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R1");
    chk(mask_o == 1'b0, "R1", 32'(mask_o), 0);

    // R4: ticks while stopped, then with run but no mode
    do_tick(0, 3); check_all("R4");
    wr_ctl(1, 0, 0); do_tick(0, 3); check_all("R4");
    wr_ctl(0, 0, 0);

    // R10: load while stopped
    wr_load(32'h0000_0100); wr_match(32'h0000_0102);
    wr_ctl(1, 1, 0);
    // R10/R11: writes while running ignored
    wr_load(32'h1234_5678); wr_match(32'h0000_0500); wr_ctl(1, 0, 1);
    check_all("R10");

    // R2: exact latency
    @(negedge clk); tick_in = 1;
    @(negedge clk); @(negedge clk);
    chk(count_o == m_cnt, "R2 early", count_o, m_cnt);
    @(negedge clk);
    chk(count_o == m_cnt + 1, "R2 latency", count_o, m_cnt + 1);
    m_cnt = m_cnt + 1;
    // R3: long level counts once
    repeat (20) @(negedge clk);
    chk(count_o == m_cnt, "R3", count_o, m_cnt);
    tick_in = 0; repeat (5) @(negedge clk);

    // R6: match then continue
    do_tick(0, 2); check_all("R6");
    chk(raw_status_o == 1'b1, "R6 set", 32'(raw_status_o), 1);
    do_tick(0, 2); check_all("R6 continues");
    // R7 sticky, then clear
    do_tick(0, 2); check_all("R7 sticky");
    wr_mask(1); check_all("R12");
    do_clear(); check_all("R7 clear");

    // R5: stall with stall-enable clear has no effect
    do_tick(1, 2); check_all("R5 off");
    wr_ctl(0, 1, 1); wr_ctl(1, 1, 1);
    do_tick(1, 2); check_all("R5 frozen");
    do_tick(0, 2); check_all("R5 free");

    // R9: wrap to zero and match at zero
    wr_ctl(0, 1, 0);
    wr_load(32'hFFFF_FFFE); wr_match(32'h0);
    wr_ctl(1, 1, 0);
    do_tick(0, 2); check_all("R9");
    do_tick(0, 2); check_all("R9 wrap");
    chk(count_o == 0 && raw_status_o, "R9", count_o, 0);

    // R8: clear in the very cycle of a match
    do_clear();
    wr_ctl(0, 1, 0); wr_match(m_cnt + 1); wr_ctl(1, 1, 0);
    @(negedge clk); tick_in = 1;
    @(negedge clk); @(negedge clk);
    int_clr = 1;                 // pulse cycle: set and clear together
    @(negedge clk); int_clr = 0; tick_in = 0;
    m_cnt = m_cnt + 1; m_stat = 1;
    repeat (4) @(negedge clk);
    check_all("R8");

    // random mix
    for (int i = 0; i < 300; i++) begin
      case ($urandom_range(0, 7))
        0: wr_ctl($urandom_range(0, 1), $urandom_range(0, 3) != 0, $urandom_range(0, 1));
        1: wr_load(m_cnt + 32'($urandom_range(0, 3)));
        2: wr_match(m_cnt + 32'($urandom_range(0, 4)));
        3: wr_mask($urandom_range(0, 1));
        4: do_clear();
        default: do_tick($urandom_range(0, 3) == 0, $urandom_range(1, 6));
      endcase
      check_all("R2/R6 random");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule